// File: doc/BRIEF.md
# Four-Stage Cascaded Watchdog

This block is a watchdog timer that runs up to four timeout stages one after another. A prescaler divides the core clock into watchdog ticks. Each stage counts ticks up to its own timeout and then carries out the action selected for it. The action is nothing, a level interrupt, a CPU reset pulse or a system reset pulse. After a stage expires the next stage starts from zero. After stage 3 the block sits idle until software feeds it. A feed restarts the whole sequence at stage 0.

All registers sit behind a key lock. Every write is dropped unless the protect word has been written with the unlock key. Any other value written there locks the block again. Reset pulses have a programmable length. Firing a reset action, or clearing the enable bit, returns the sequence to stage 0.

Word addresses are: 0 control, 1 prescale, 2 to 5 the timeouts of stages 0 to 3, 6 feed, 7 interrupt clear (a read returns the interrupt level in bit 0), and 8 protect. Reads are combinational from the address.

Top module: `staged_watchdog`

## Requirements
- R1: After reset, the three outputs are low, the protect word reads 1 (locked) and the control word reads 0.
- R2: While locked, writes to every address except 8 leave all state unchanged. Writing the key to address 8 unlocks the block, so a read of address 8 returns 0. Writing any other value, including 0, locks it again.
- R3: With prescale value P at address 1 (P = 0 behaves as 1), one tick occurs every P clock cycles, counted from the edge that sets the enable bit or feeds. An active stage with timeout T (T = 0 behaves as 1) expires on its T-th tick.
- R4: The stage action is a 2-bit code in control bits [2s+1:2s] for stage s. Code 0 skips the stage and uses up one tick. Code 1 raises the interrupt. Code 2 starts the CPU reset pulse. Code 3 starts the system reset pulse. Each action appears on its output in the cycle after the expiring tick's edge.
- R5: Stages run in the order 0, 1, 2, 3. When stage 3 has been handled without a reset action, the block stays idle until it is fed.
- R6: Writing a word with bit 0 set to address 6 restarts the sequence at stage 0 with the stage counter and the prescaler cleared.
- R7: The interrupt output is a level. It stays high until a word with bit 0 set is written to address 7. A feed does not clear it.
- R8: The CPU reset pulse lasts (L+1)·PULSE_UNIT cycles, where L is control bits [10:8]. The system reset pulse lasts (L+1)·PULSE_UNIT cycles, where L is bits [13:11].
- R9: A stage that fires a CPU or system reset sends the sequence back to stage 0, and the counting continues from there.
- R10: Control bit 14 enables the block. While it is clear no ticks occur, and the stage and counter are held at stage 0 with a count of 0.
- R11: Control bit 15 is a stored boot-mode enable. It reads back as written and has no effect on timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_o | output | 1 | Level interrupt |
| cpu_rst_o | output | 1 | CPU reset pulse |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
A table of configurations drives the sequencer with different prescale values (0, 1, 2 and 3), different action patterns (a single active stage at each position behind skipped stages) and zero and non-zero timeouts. The number of cycles to the first output and which output rises are compared against tick arithmetic. This separates errors in tick spacing, in the skip rule and in the action decode. Directed cases cover the following: a feed just before expiry, which must delay the interrupt by a full period; the interrupt persisting across a feed; pulse widths for two length codes; the restart after a reset action, which shows up as a second interrupt; idling after stage 3; clearing the enable bit mid-count; and the key lock.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int unsigned NUM_STG = 4;
    localparam int unsigned STG_W   = 2;
    localparam int unsigned LEN_W   = 3;
    localparam int unsigned ADDR_W  = 4;
    localparam int unsigned DATA_W  = 32;

    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t A_CTRL = 4'd0;
    localparam addr_t A_PRE  = 4'd1;
    localparam addr_t A_TMO0 = 4'd2;
    localparam addr_t A_FEED = 4'd6;
    localparam addr_t A_ICLR = 4'd7;
    localparam addr_t A_KEY  = 4'd8;

    typedef enum logic [1:0] {
        ACT_OFF = 2'd0,
        ACT_IRQ = 2'd1,
        ACT_CPU = 2'd2,
        ACT_SYS = 2'd3
    } act_e;

    // Control word: boot[15] en[14] sys_len[13:11] cpu_len[10:8] act[7:0]
    typedef struct packed {
        logic                         boot_en;
        logic                         run_en;
        logic [LEN_W-1:0]             sys_len;
        logic [LEN_W-1:0]             cpu_len;
        logic [NUM_STG-1:0][1:0]      act;
    } ctrl_t;

    typedef struct packed {
        logic irq;
        logic cpu;
        logic sys;
    } fire_t;

    function automatic act_e stage_act(input logic [NUM_STG-1:0][1:0] acts,
                                       input logic [STG_W-1:0] s);
        return act_e'(acts[s]);
    endfunction

    function automatic logic is_reset_act(input act_e a);
        return (a == ACT_CPU) || (a == ACT_SYS);
    endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter logic [31:0] KEY   = 32'hA5C3_19E7,
    parameter int unsigned PRE_W = 16,
    parameter int unsigned CNT_W = 32
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            bus_wr,
    input  addr_t                           bus_addr,
    input  logic [DATA_W-1:0]               bus_wdata,
    input  logic                            irq_lvl,
    output logic [DATA_W-1:0]               bus_rdata,
    output ctrl_t                           ctrl_o,
    output logic [PRE_W-1:0]                presc_o,
    output logic [NUM_STG-1:0][CNT_W-1:0]   tmo_o,
    output logic                            feed_o,
    output logic                            iclr_o
);

    logic  locked_q;
    logic  wr_ok;
    ctrl_t ctrl_q;
    logic [PRE_W-1:0] presc_q;
    logic [NUM_STG-1:0][CNT_W-1:0] tmo_q;

    assign wr_ok  = bus_wr && !locked_q;
    assign feed_o = wr_ok && (bus_addr == A_FEED) && bus_wdata[0];
    assign iclr_o = wr_ok && (bus_addr == A_ICLR) && bus_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q <= 1'b1;
        end else if (bus_wr && (bus_addr == A_KEY)) begin
            locked_q <= (bus_wdata != KEY);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            presc_q <= '0;
        end else if (wr_ok) begin
            if (bus_addr == A_CTRL) ctrl_q  <= ctrl_t'(bus_wdata[$bits(ctrl_t)-1:0]);
            if (bus_addr == A_PRE)  presc_q <= bus_wdata[PRE_W-1:0];
        end
    end

    for (genvar g = 0; g < NUM_STG; g++) begin : g_tmo
        localparam addr_t MY_ADDR = addr_t'(A_TMO0 + g);
        always_ff @(posedge clk) begin
            if (rst) begin
                tmo_q[g] <= '0;
            end else if (wr_ok && (bus_addr == MY_ADDR)) begin
                tmo_q[g] <= bus_wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  bus_rdata = DATA_W'(ctrl_q);
            A_PRE:   bus_rdata = DATA_W'(presc_q);
            A_ICLR:  bus_rdata = DATA_W'(irq_lvl);
            A_KEY:   bus_rdata = DATA_W'(locked_q);
            default: bus_rdata = '0;
        endcase
        for (int i = 0; i < NUM_STG; i++) begin
            if (bus_addr == addr_t'(A_TMO0 + i)) bus_rdata = DATA_W'(tmo_q[i]);
        end
    end

    assign ctrl_o  = ctrl_q;
    assign presc_o = presc_q;
    assign tmo_o   = tmo_q;

    // R2
    locked_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
        (locked_q && bus_wr && bus_addr == A_CTRL) |=> $stable(ctrl_q));

endmodule

// File: rtl/wdog_tick.sv
module wdog_tick #(
    parameter int unsigned PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] presc,
    output logic             tick_o
);

    logic [PRE_W-1:0] pc_q;
    logic [PRE_W-1:0] lim;

    assign lim    = (presc == '0) ? '0 : presc - 1'b1;
    assign tick_o = run && (pc_q == lim);

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            pc_q <= '0;
        end else if (tick_o) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdog_seq.sv
module wdog_seq
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           run,
    input  logic                           feed,
    input  logic                           tick,
    input  logic [NUM_STG-1:0][1:0]        acts,
    input  logic [NUM_STG-1:0][CNT_W-1:0]  tmo,
    input  logic                           irq_clr,
    output logic                           irq_o,
    output fire_t                          fire_o
);

    logic [STG_W-1:0] stg_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic             irq_q;

    act_e             cur_act;
    logic [CNT_W:0]   cnt_nx;
    logic [CNT_W:0]   limit;
    logic             step;
    logic             expire;

    assign cur_act = stage_act(acts, stg_q);
    assign cnt_nx  = {1'b0, cnt_q} + 1'b1;
    assign limit   = (tmo[stg_q] == '0) ? (CNT_W+1)'(1) : {1'b0, tmo[stg_q]};
    assign step    = run && !feed && tick && !done_q;
    assign expire  = step && (cur_act != ACT_OFF) && (cnt_nx >= limit);

    assign fire_o.irq = expire && (cur_act == ACT_IRQ);
    assign fire_o.cpu = expire && (cur_act == ACT_CPU);
    assign fire_o.sys = expire && (cur_act == ACT_SYS);

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!run || feed) begin
            stg_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (step) begin
            if (expire && is_reset_act(cur_act)) begin
                stg_q <= '0;
                cnt_q <= '0;
            end else if (expire || cur_act == ACT_OFF) begin
                cnt_q <= '0;
                if (stg_q == STG_W'(NUM_STG-1)) done_q <= 1'b1;
                else                            stg_q  <= stg_q + 1'b1;
            end else begin
                cnt_q <= cnt_nx[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)             irq_q <= 1'b0;
        else if (fire_o.irq) irq_q <= 1'b1;
        else if (irq_clr)    irq_q <= 1'b0;
    end

    assign irq_o = irq_q;

    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !irq_clr) |=> irq_q);

    // R6
    feed_restart_chk: assert property (@(posedge clk) disable iff (rst)
        feed |=> (stg_q == '0 && cnt_q == '0 && !done_q));

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (done_q && run && !feed) |=> (done_q && cnt_q == '0));

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse
    import wdog_pkg::*;
#(
    parameter int unsigned UNIT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    output logic             busy_o
);

    localparam int unsigned MAX_CNT = (1 << LEN_W) * UNIT;
    localparam int unsigned CW      = $clog2(MAX_CNT + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] load;

    assign load   = CW'((32'(len) + 32'd1) * UNIT);
    assign busy_o = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (start)  cnt_q <= load;
        else if (busy_o) cnt_q <= cnt_q - 1'b1;
    end

    // R8
    pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> busy_o);

endmodule

// File: rtl/staged_watchdog.sv
module staged_watchdog
    import wdog_pkg::*;
#(
    parameter logic [31:0] KEY        = 32'hA5C3_19E7,
    parameter int unsigned PRE_W      = 16,
    parameter int unsigned CNT_W      = 32,
    parameter int unsigned PULSE_UNIT = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_o,
    output logic        cpu_rst_o,
    output logic        sys_rst_o
);

    ctrl_t                          ctrl;
    logic [PRE_W-1:0]               presc;
    logic [NUM_STG-1:0][CNT_W-1:0]  tmo;
    logic                           feed;
    logic                           iclr;
    logic                           tick;
    fire_t                          fire;
    logic [1:0]                     pls_start;
    logic [1:0][LEN_W-1:0]          pls_len;
    logic [1:0]                     pls_busy;

    wdog_regs #(.KEY(KEY), .PRE_W(PRE_W), .CNT_W(CNT_W)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .irq_lvl   (irq_o),
        .bus_rdata (bus_rdata),
        .ctrl_o    (ctrl),
        .presc_o   (presc),
        .tmo_o     (tmo),
        .feed_o    (feed),
        .iclr_o    (iclr)
    );

    wdog_tick #(.PRE_W(PRE_W)) tick_i (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl.run_en),
        .restart (feed),
        .presc   (presc),
        .tick_o  (tick)
    );

    wdog_seq #(.CNT_W(CNT_W)) seq_i (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl.run_en),
        .feed    (feed),
        .tick    (tick),
        .acts    (ctrl.act),
        .tmo     (tmo),
        .irq_clr (iclr),
        .irq_o   (irq_o),
        .fire_o  (fire)
    );

    assign pls_start = {fire.sys, fire.cpu};
    assign pls_len   = {ctrl.sys_len, ctrl.cpu_len};

    for (genvar p = 0; p < 2; p++) begin : g_pulse
        wdog_pulse #(.UNIT(PULSE_UNIT)) pulse_i (
            .clk    (clk),
            .rst    (rst),
            .start  (pls_start[p]),
            .len    (pls_len[p]),
            .busy_o (pls_busy[p])
        );
    end

    assign cpu_rst_o = pls_busy[0];
    assign sys_rst_o = pls_busy[1];

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!irq_o && !cpu_rst_o && !sys_rst_o));

endmodule

// File: tb/staged_watchdog_tb.sv
module staged_watchdog_tb_top;

    localparam logic [31:0] KEY = 32'hA5C3_19E7;

    typedef struct packed {
        logic [7:0]  presc;
        logic [7:0]  acts;
        logic [7:0]  t0;
        logic [7:0]  t1;
        logic [7:0]  t2;
        logic [7:0]  t3;
        logic [15:0] cyc;
        logic [1:0]  kind;   // 1 irq, 2 cpu, 3 sys
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        {8'd2, 8'h01, 8'd3, 8'd0, 8'd0, 8'd0, 16'd6,  2'd1},
        {8'd2, 8'h08, 8'd0, 8'd5, 8'd0, 8'd0, 16'd12, 2'd2},
        {8'd2, 8'hC0, 8'd0, 8'd0, 8'd0, 8'd2, 16'd10, 2'd3},
        {8'd2, 8'h01, 8'd0, 8'd0, 8'd0, 8'd0, 16'd2,  2'd1},
        {8'd3, 8'h04, 8'd0, 8'd4, 8'd0, 8'd0, 16'd15, 2'd1},
        {8'd1, 8'h30, 8'd0, 8'd0, 8'd3, 8'd0, 16'd5,  2'd3},
        {8'd0, 8'h01, 8'd7, 8'd0, 8'd0, 8'd0, 16'd7,  2'd1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq_o, cpu_rst_o, sys_rst_o;

    int nchk  = 0;
    int nfail = 0;
    vec_t cur;
    int n;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    staged_watchdog #(.KEY(KEY), .PULSE_UNIT(4)) dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .cpu_rst_o(cpu_rst_o), .sys_rst_o(sys_rst_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic prep(input logic [31:0] p, input logic [31:0] a0, input logic [31:0] a1,
                        input logic [31:0] a2, input logic [31:0] a3);
        wr(4'd8, KEY);
        wr(4'd0, 32'h0);
        wr(4'd7, 32'h1);
        repeat (20) step();
        wr(4'd1, p);
        wr(4'd2, a0);
        wr(4'd3, a1);
        wr(4'd4, a2);
        wr(4'd5, a3);
    endtask

    task automatic wait_any(input int lim);
        n = 0;
        while (n < lim && !(irq_o || cpu_rst_o || sys_rst_o)) begin
            step();
            n++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;

        // R1 reset state
        chk("R1 outputs", {29'd0, irq_o, cpu_rst_o, sys_rst_o}, 32'd0);
        rd(4'd8, rv); chk("R1 locked", rv, 32'd1);
        rd(4'd0, rv); chk("R1 ctrl", rv, 32'd0);

        // R3/R4 table: cycles to first output and which output
        for (int v = 0; v < NVEC; v++) begin
            cur = VECS[v];
            prep(32'(cur.presc), 32'(cur.t0), 32'(cur.t1), 32'(cur.t2), 32'(cur.t3));
            wr(4'd0, 32'h4900 | 32'(cur.acts));
            wait_any(400);
            chk("R3 cycles", 32'(n), 32'(cur.cyc));
            chk("R4 kind", sys_rst_o ? 32'd3 : cpu_rst_o ? 32'd2 : irq_o ? 32'd1 : 32'd0,
                32'(cur.kind));
        end

        // R6 feed before expiry delays the interrupt by a full period
        prep(32'd2, 32'd4, 32'd0, 32'd0, 32'd0);
        wr(4'd0, 32'h4001);
        repeat (5) step();
        wr(4'd6, 32'h1);
        repeat (7) step();
        chk("R6 no irq before period", 32'(irq_o), 32'd0);
        step();
        chk("R6 irq after period", 32'(irq_o), 32'd1);

        // R7 feed does not clear; clear register does
        wr(4'd6, 32'h1);
        chk("R7 held over feed", 32'(irq_o), 32'd1);
        wr(4'd7, 32'h1);
        chk("R7 cleared", 32'(irq_o), 32'd0);

        // R9 and R8: stage0 irq T=3, stage1 cpu T=10, P=2, cpu len 1
        prep(32'd2, 32'd3, 32'd10, 32'd0, 32'd0);
        wr(4'd0, 32'h4109);
        n = 0;
        while (n < 200 && !cpu_rst_o) begin step(); n++; end
        chk("R4 cpu at tick 13", 32'(n), 32'd26);
        wr(4'd7, 32'h1);
        chk("R7 clear", 32'(irq_o), 32'd0);
        repeat (4) step();
        chk("R9 no irq yet", 32'(irq_o), 32'd0);
        step();
        chk("R9 restart irq", 32'(irq_o), 32'd1);
        step();
        chk("R8 cpu last cycle", 32'(cpu_rst_o), 32'd1);
        step();
        chk("R8 cpu ended", 32'(cpu_rst_o), 32'd0);

        // R8 system pulse, len 2 -> 12 cycles
        prep(32'd1, 32'd20, 32'd0, 32'd0, 32'd0);
        wr(4'd0, 32'h5003);
        wait_any(200);
        chk("R8 sys start", 32'(n), 32'd20);
        repeat (11) step();
        chk("R8 sys last cycle", 32'(sys_rst_o), 32'd1);
        step();
        chk("R8 sys ended", 32'(sys_rst_o), 32'd0);

        // R5 idle after stage 3
        prep(32'd1, 32'd0, 32'd0, 32'd0, 32'd2);
        wr(4'd0, 32'h4040);
        wait_any(200);
        chk("R5 stage3 irq", 32'(n), 32'd5);
        wr(4'd7, 32'h1);
        repeat (30) step();
        chk("R5 idle", 32'(irq_o), 32'd0);

        // R10 disable clears the count
        prep(32'd1, 32'd4, 32'd0, 32'd0, 32'd0);
        wr(4'd0, 32'h4001);
        repeat (2) step();
        wr(4'd0, 32'h0001);
        repeat (10) step();
        chk("R10 disabled quiet", 32'(irq_o), 32'd0);
        wr(4'd0, 32'h4001);
        repeat (3) step();
        chk("R10 full period again", 32'(irq_o), 32'd0);
        step();
        chk("R10 expiry", 32'(irq_o), 32'd1);

        // R2 lock
        wr(4'd8, 32'h0);
        rd(4'd8, rv); chk("R2 locked", rv, 32'd1);
        wr(4'd0, 32'h0000);
        rd(4'd0, rv); chk("R2 write ignored", rv, 32'h4001);
        wr(4'd7, 32'h1);
        chk("R2 clear ignored", 32'(irq_o), 32'd1);
        wr(4'd8, KEY);
        rd(4'd8, rv); chk("R2 unlocked", rv, 32'd0);

        // R11 boot bit stored
        wr(4'd0, 32'h8000);
        rd(4'd0, rv); chk("R11 boot bit", rv, 32'h8000);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule